// File: doc/BRIEF.md
# Multi-Sector Erase Scheduler With Suspend

This block sits behind the command decoder of a sector-organised non-volatile array. It takes sector-erase requests one at a time and gathers them into a bit mask, one bit per sector. The first request opens a collection window that is timed in microsecond ticks. Each further request made while the window is open adds its sector and restarts the window. When the window runs out, write-protected sectors are removed from the mask. The remaining sectors are then erased one after another, and a tick counter stands in for the real erase time of each sector.

While the erase runs, the host can only suspend it or resume it. Any other command aborts the erase, and the abort is reported as leaving the erased data invalid. A suspend is also accepted while the window is still open. The suspended state is reached after a fixed number of ticks. A resume starts erasing at once, with no new window. If every chosen sector is protected, the block stays busy for a short fixed time and then returns to read mode with nothing changed.

Top module: `erase_sched`

## Requirements
- R1: After reset, and whenever the block is back in read mode, `busy`, `suspended`, `window_open`, `abort_read` and `abort_dirty` are 0 and `erase_mask` is all zeros.
- R2: In read mode, a `cmd_sect_erase` pulse opens the window. On the next cycle `busy` and `window_open` are 1, and `erase_mask` has only bit `cmd_sect_idx` set (bit i stands for sector i).
- R3: While the window is open, each `cmd_sect_erase` sets its bit in the mask, keeps every bit already set, and restarts the window. The window closes on the WIN_TICKS-th `tick_us` after the last addition. `window_open` is 1 only while sectors can still be added and drops to 0 once the erase has started.
- R4: A `cmd_other` while the window is open cancels the request. On the next cycle the block is in read mode with an empty mask, and `abort_read` is 1 for that one cycle while `abort_dirty` stays 0.
- R5: While the erase runs, a `cmd_other` or a `cmd_sect_erase` aborts it. On the next cycle the block is in read mode, and both `abort_read` and `abort_dirty` are 1 for one cycle. A `cmd_resume` while running has no effect.
- R6: A `cmd_suspend` while the window is open or while erasing keeps `busy` at 1. After SUSP_TICKS ticks, `suspended` becomes 1 and `busy` becomes 0, and the mask is kept. Commands given while the suspend is pending are ignored.
- R7: While suspended, only `cmd_resume` has an effect. It restarts the erase on the next cycle with no window (`busy` 1, `window_open` 0), and the tick count of the current sector starts again from zero.
- R8: When the erase starts (the window closes or a resume is given), sectors set in `protect_mask` are removed from the mask. If none are left, `busy` stays 1 for NOPROT_TICKS ticks with an empty mask, and the block then returns to read mode without an abort.
- R9: Sectors are erased one at a time, lowest index first. Each takes ERASE_TICKS ticks, and its bit clears when it finishes. `busy` falls in the same cycle that the last bit clears.
- R10: A `cmd_suspend` or `cmd_resume` given in read mode is ignored.
- R11: If several command inputs are high in the same cycle, only one is acted on. The order of precedence is `cmd_other`, then `cmd_suspend`, then `cmd_resume`, then `cmd_sect_erase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle time base pulse (one microsecond) |
| cmd_sect_erase | input | 1 | Sector-erase command pulse |
| cmd_sect_idx | input | SIDX_W | Sector index of the erase command |
| cmd_suspend | input | 1 | Erase-suspend command pulse |
| cmd_resume | input | 1 | Erase-resume command pulse |
| cmd_other | input | 1 | Any other command pulse |
| protect_mask | input | NUM_SECT | Write-protected sectors |
| erase_mask | output | NUM_SECT | Sectors still to be erased |
| busy | output | 1 | Window open, erasing, suspend pending, or all-protected wait |
| suspended | output | 1 | Erase suspended |
| window_open | output | 1 | Further sectors can still be added |
| abort_read | output | 1 | One-cycle pulse: request cancelled, back to read mode |
| abort_dirty | output | 1 | One-cycle pulse with `abort_read` when erase data became invalid |

## Verification
The bench adds sectors late in the window to check that each addition restarts the window. A design that did not restart it would start the erase early, and `window_open` would fall too soon. It also gives a suspend while the window is open and a resume during the suspend. A design that wrongly opened a new window on resume would show `window_open` rising again. Other cases are masks whose sectors are all protected and masks that are only partly protected. A design that filtered protection at the wrong moment would erase a protected sector, or would abort instead of waiting out the all-protected time. Commands given during a pending suspend or during an erase are also exercised: a design that ignored the abort rule would keep `busy` high after a stray sector-erase command.

// File: rtl/erase_sched_pkg.sv
package erase_sched_pkg;

   typedef enum logic [2:0] {
      ES_IDLE   = 3'd0,
      ES_WIN    = 3'd1,
      ES_RUN    = 3'd2,
      ES_SPEND  = 3'd3,
      ES_SUSP   = 3'd4,
      ES_NOPROT = 3'd5
   } es_state_t;

   typedef enum logic [2:0] {
      EC_NONE  = 3'd0,
      EC_OTHER = 3'd1,
      EC_SUSP  = 3'd2,
      EC_RES   = 3'd3,
      EC_ADD   = 3'd4
   } es_cmd_t;

   function automatic int unsigned es_max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/es_cmd_classify.sv
module es_cmd_classify
   import erase_sched_pkg::*;
(
   input  logic    add_i,
   input  logic    susp_i,
   input  logic    res_i,
   input  logic    oth_i,
   output es_cmd_t cmd_o
);
   // R11 precedence: other, suspend, resume, sector erase
   always_comb begin
      if (oth_i)       cmd_o = EC_OTHER;
      else if (susp_i) cmd_o = EC_SUSP;
      else if (res_i)  cmd_o = EC_RES;
      else if (add_i)  cmd_o = EC_ADD;
      else             cmd_o = EC_NONE;
   end
endmodule

// File: rtl/es_pick_sector.sv
module es_pick_sector #(
   parameter int N       = 8,
   parameter bit SCAN_UP = 1'b1
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] pick_o
);
   logic [N:0] seen;

   generate
      if (SCAN_UP) begin : g_up
         assign seen[0] = 1'b0;
         for (genvar i = 0; i < N; i++) begin : g_bit
            assign pick_o[i]  = req_i[i] & ~seen[i];
            assign seen[i+1]  = seen[i] | req_i[i];
         end
      end else begin : g_down
         assign seen[N] = 1'b0;
         for (genvar i = N - 1; i >= 0; i--) begin : g_bit
            assign pick_o[i] = req_i[i] & ~seen[i+1];
            assign seen[i]   = seen[i+1] | req_i[i];
         end
      end
   endgenerate
endmodule

// File: rtl/es_tick_timer.sv
module es_tick_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             hit_o
);
   logic [CNT_W-1:0] cnt_q;

   assign hit_o = tick_i && (cnt_q == limit_i - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (hit_o) cnt_q <= '0;
         else       cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/erase_sched.sv
module erase_sched
   import erase_sched_pkg::*;
#(
   parameter int NUM_SECT     = 8,
   parameter int WIN_TICKS    = 100,
   parameter int ERASE_TICKS  = 1000,
   parameter int SUSP_TICKS   = 70,
   parameter int NOPROT_TICKS = 2,
   parameter bit SCAN_UP      = 1'b1,
   localparam int SIDX_W      = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_us,
   input  logic                cmd_sect_erase,
   input  logic [SIDX_W-1:0]   cmd_sect_idx,
   input  logic                cmd_suspend,
   input  logic                cmd_resume,
   input  logic                cmd_other,
   input  logic [NUM_SECT-1:0] protect_mask,
   output logic [NUM_SECT-1:0] erase_mask,
   output logic                busy,
   output logic                suspended,
   output logic                window_open,
   output logic                abort_read,
   output logic                abort_dirty
);
   localparam int unsigned MAX_T = es_max2(es_max2(WIN_TICKS, ERASE_TICKS),
                                           es_max2(SUSP_TICKS, NOPROT_TICKS));
   localparam int CNT_W = $clog2(MAX_T + 1);

   generate
      if (NUM_SECT < 2) begin : g_bad_n
         $error("erase_sched: NUM_SECT must be at least 2");
      end
      if (WIN_TICKS < 1 || ERASE_TICKS < 1 || SUSP_TICKS < 1 || NOPROT_TICKS < 1) begin : g_bad_t
         $error("erase_sched: every tick count must be at least 1");
      end
   endgenerate

   es_state_t            st_q, st_d;
   logic [NUM_SECT-1:0]  mask_q, mask_d;
   logic                 ab_d, dirty_d;
   logic                 add_in_win, go_run;
   es_cmd_t              cmd;
   logic [NUM_SECT-1:0]  sel_oh, cur_oh, filt;
   logic [CNT_W-1:0]     limit;
   logic                 hit, tmr_clr;

   es_cmd_classify u_cls (
      .add_i  (cmd_sect_erase),
      .susp_i (cmd_suspend),
      .res_i  (cmd_resume),
      .oth_i  (cmd_other),
      .cmd_o  (cmd)
   );

   es_pick_sector #(.N(NUM_SECT), .SCAN_UP(SCAN_UP)) u_pick (
      .req_i  (mask_q),
      .pick_o (cur_oh)
   );

   always_comb begin
      case (st_q)
         ES_WIN:    limit = CNT_W'(WIN_TICKS);
         ES_RUN:    limit = CNT_W'(ERASE_TICKS);
         ES_SPEND:  limit = CNT_W'(SUSP_TICKS);
         ES_NOPROT: limit = CNT_W'(NOPROT_TICKS);
         default:   limit = CNT_W'(WIN_TICKS);
      endcase
   end

   es_tick_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (tmr_clr),
      .tick_i  (tick_us),
      .limit_i (limit),
      .hit_o   (hit)
   );

   assign sel_oh = NUM_SECT'(1) << cmd_sect_idx;
   assign filt   = mask_q & ~protect_mask;

   always_comb begin
      st_d       = st_q;
      mask_d     = mask_q;
      ab_d       = 1'b0;
      dirty_d    = 1'b0;
      add_in_win = 1'b0;
      go_run     = 1'b0;
      case (st_q)
         ES_IDLE: begin
            if (cmd == EC_ADD) begin
               st_d   = ES_WIN;
               mask_d = sel_oh;
            end
         end
         ES_WIN: begin
            case (cmd)
               EC_OTHER: begin
                  st_d   = ES_IDLE;
                  mask_d = '0;
                  ab_d   = 1'b1;
               end
               EC_SUSP: st_d = ES_SPEND;
               EC_ADD: begin
                  mask_d     = mask_q | sel_oh;
                  add_in_win = 1'b1;
               end
               default: if (hit) go_run = 1'b1;
            endcase
         end
         ES_RUN: begin
            case (cmd)
               EC_OTHER, EC_ADD: begin
                  st_d    = ES_IDLE;
                  mask_d  = '0;
                  ab_d    = 1'b1;
                  dirty_d = 1'b1;
               end
               EC_SUSP: st_d = ES_SPEND;
               default: begin
                  if (hit) begin
                     mask_d = mask_q & ~cur_oh;
                     if ((mask_q & ~cur_oh) == '0) st_d = ES_IDLE;
                  end
               end
            endcase
         end
         ES_SPEND:  if (hit) st_d = ES_SUSP;
         ES_SUSP:   if (cmd == EC_RES) go_run = 1'b1;
         ES_NOPROT: if (hit) st_d = ES_IDLE;
         default: begin
            st_d   = ES_IDLE;
            mask_d = '0;
         end
      endcase
      if (go_run) begin
         if (filt == '0) begin
            st_d   = ES_NOPROT;
            mask_d = '0;
         end else begin
            st_d   = ES_RUN;
            mask_d = filt;
         end
      end
   end

   assign tmr_clr = (st_q == ES_IDLE) || (st_d != st_q) || add_in_win;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ES_IDLE;
         mask_q      <= '0;
         abort_read  <= 1'b0;
         abort_dirty <= 1'b0;
      end else begin
         st_q        <= st_d;
         mask_q      <= mask_d;
         abort_read  <= ab_d;
         abort_dirty <= dirty_d;
      end
   end

   assign erase_mask  = mask_q;
   assign busy        = (st_q == ES_WIN) || (st_q == ES_RUN) ||
                        (st_q == ES_SPEND) || (st_q == ES_NOPROT);
   assign suspended   = (st_q == ES_SUSP);
   assign window_open = (st_q == ES_WIN);
endmodule

// File: rtl/es_sched_chk.sv
module es_sched_chk #(
   parameter int NUM_SECT = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_suspend,
   input logic                cmd_sect_erase,
   input logic                cmd_other,
   input logic [NUM_SECT-1:0] erase_mask,
   input logic                busy,
   input logic                suspended,
   input logic                window_open,
   input logic                abort_read,
   input logic                abort_dirty
);
   a_r1_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !suspended) |-> (erase_mask == '0));

   a_r3_win_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (window_open && $past(window_open)) |-> ((erase_mask & $past(erase_mask)) == $past(erase_mask)));

   a_r4_abort_to_read: assert property (@(posedge clk) disable iff (!rst_n)
      abort_read |-> (!busy && !suspended && erase_mask == '0));

   a_r5_dirty_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
      abort_dirty |-> abort_read);

   a_r6_susp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && suspended));

   a_r6_susp_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspended) |-> $past(busy));

   a_r7_resume_no_window: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(suspended) |-> (busy && !window_open));

   a_r9_no_new_bits: assert property (@(posedge clk) disable iff (!rst_n)
      !window_open |-> ((erase_mask & ~$past(erase_mask)) == '0));

   a_r10_idle_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !suspended && cmd_suspend && !cmd_other) |=> (!busy && !suspended));
endmodule

bind erase_sched es_sched_chk #(.NUM_SECT(NUM_SECT)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_suspend    (cmd_suspend),
   .cmd_sect_erase (cmd_sect_erase),
   .cmd_other      (cmd_other),
   .erase_mask     (erase_mask),
   .busy           (busy),
   .suspended      (suspended),
   .window_open    (window_open),
   .abort_read     (abort_read),
   .abort_dirty    (abort_dirty)
);

// File: tb/sim_erase_sched.sv
module sim_erase_sched;
   localparam int CLK_PERIOD = 10;
   localparam int NS  = 8;
   localparam int IW  = $clog2(NS);
   localparam int WT  = 4;
   localparam int ET  = 3;
   localparam int ST  = 2;
   localparam int NT  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_us = 1'b0;
   logic          cmd_sect_erase = 1'b0;
   logic [IW-1:0] cmd_sect_idx = '0;
   logic          cmd_suspend = 1'b0;
   logic          cmd_resume = 1'b0;
   logic          cmd_other = 1'b0;
   logic [NS-1:0] protect_mask = '0;
   logic [NS-1:0] erase_mask;
   logic          busy, suspended, window_open, abort_read, abort_dirty;

   int n_chk = 0;
   int n_bad = 0;

   // bench model: 0 read, 1 window, 2 erasing, 3 suspend pending, 4 suspended, 5 all-protected wait
   int            m_st = 0;
   int            m_cnt = 0;
   logic [NS-1:0] m_mask = '0;
   logic          m_ab = 1'b0, m_dirty = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   erase_sched #(
      .NUM_SECT(NS), .WIN_TICKS(WT), .ERASE_TICKS(ET),
      .SUSP_TICKS(ST), .NOPROT_TICKS(NT), .SCAN_UP(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
      .cmd_sect_erase(cmd_sect_erase), .cmd_sect_idx(cmd_sect_idx),
      .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_other(cmd_other),
      .protect_mask(protect_mask), .erase_mask(erase_mask), .busy(busy),
      .suspended(suspended), .window_open(window_open),
      .abort_read(abort_read), .abort_dirty(abort_dirty)
   );

   function automatic logic [NS-1:0] drop_lowest(input logic [NS-1:0] v);
      return v & (v - 1'b1);
   endfunction

   task automatic begin_erase();
      logic [NS-1:0] left;
      left  = m_mask & ~protect_mask;
      m_cnt = 0;
      if (left == '0) begin
         m_mask = '0;
         m_st   = 5;
      end else begin
         m_mask = left;
         m_st   = 2;
      end
   endtask

   task automatic model_step();
      bit o, s, r, a;
      o = cmd_other;
      s = cmd_suspend && !o;
      r = cmd_resume && !o && !s;
      a = cmd_sect_erase && !o && !s && !r;
      m_ab = 1'b0;
      m_dirty = 1'b0;
      case (m_st)
         0: begin
            m_cnt = 0;
            if (a) begin
               m_mask = '0;
               m_mask[cmd_sect_idx] = 1'b1;
               m_st = 1;
            end
         end
         1: begin
            if (o) begin
               m_st = 0; m_mask = '0; m_ab = 1'b1; m_cnt = 0;
            end else if (s) begin
               m_st = 3; m_cnt = 0;
            end else if (a) begin
               m_mask[cmd_sect_idx] = 1'b1; m_cnt = 0;
            end else if (tick_us) begin
               if (m_cnt == WT - 1) begin_erase();
               else m_cnt++;
            end
         end
         2: begin
            if (o || a) begin
               m_st = 0; m_mask = '0; m_ab = 1'b1; m_dirty = 1'b1; m_cnt = 0;
            end else if (s) begin
               m_st = 3; m_cnt = 0;
            end else if (tick_us) begin
               if (m_cnt == ET - 1) begin
                  m_mask = drop_lowest(m_mask);
                  m_cnt = 0;
                  if (m_mask == '0) m_st = 0;
               end else m_cnt++;
            end
         end
         3: if (tick_us) begin
            if (m_cnt == ST - 1) begin m_st = 4; m_cnt = 0; end
            else m_cnt++;
         end
         4: if (r) begin_erase();
         default: if (tick_us) begin
            if (m_cnt == NT - 1) begin m_st = 0; m_cnt = 0; end
            else m_cnt++;
         end
      endcase
   endtask

   task automatic check_eq(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic compare(input string tag);
      logic eb;
      eb = (m_st == 1) || (m_st == 2) || (m_st == 3) || (m_st == 5);
      n_chk++;
      if (busy !== eb || suspended !== (m_st == 4) || window_open !== (m_st == 1) ||
          erase_mask !== m_mask || abort_read !== m_ab || abort_dirty !== m_dirty) begin
         n_bad++;
         $display("FAIL %s: got b%b s%b w%b m%h a%b d%b expected b%b s%b w%b m%h a%b d%b", tag,
                  busy, suspended, window_open, erase_mask, abort_read, abort_dirty,
                  eb, m_st == 4, m_st == 1, m_mask, m_ab, m_dirty);
      end
   endtask

   // one cycle: drive at negedge, step model, clock, compare at next negedge
   task automatic cyc(input bit o, input bit s, input bit r, input bit a,
                      input int idx, input bit tk, input string tag);
      cmd_other = o; cmd_suspend = s; cmd_resume = r; cmd_sect_erase = a;
      cmd_sect_idx = IW'(idx); tick_us = tk;
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 1, tag);
   endtask

   task automatic finish_run(input string tag);
      for (int i = 0; i < 200 && (busy || suspended); i++) begin
         if (suspended) cyc(0, 0, 1, 0, 0, 1, tag);
         else cyc(0, 0, 0, 0, 0, 1, tag);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_eq("R1", "busy", busy, 0);
      check_eq("R1", "suspended", suspended, 0);
      check_eq("R1", "window", window_open, 0);
      check_eq("R1", "mask", erase_mask, 0);
      check_eq("R1", "abort", {abort_read, abort_dirty}, 0);

      // R10 suspend/resume in read mode ignored
      cyc(0, 1, 0, 0, 0, 1, "R10");
      cyc(0, 0, 1, 0, 0, 1, "R10");
      check_eq("R10", "busy", busy, 0);

      // R2 open window, R3 additions restart it
      cyc(0, 0, 0, 1, 5, 0, "R2");
      check_eq("R2", "mask", erase_mask, 32'h20);
      check_eq("R2", "window", window_open, 1);
      ticks(WT - 1, "R3");
      cyc(0, 0, 0, 1, 1, 0, "R3");
      check_eq("R3", "mask", erase_mask, 32'h22);
      ticks(WT - 1, "R3");
      check_eq("R3", "window still open", window_open, 1);
      ticks(1, "R3");
      check_eq("R3", "window closed", window_open, 0);
      check_eq("R3", "busy running", busy, 1);
      // R9 lowest sector first, R5 resume ignored while running
      cyc(0, 0, 1, 0, 0, 1, "R5");
      ticks(ET - 1, "R9");
      check_eq("R9", "mask after first sector", erase_mask, 32'h20);
      ticks(ET - 1, "R9");
      check_eq("R9", "busy before last", busy, 1);
      ticks(1, "R9");
      check_eq("R9", "busy after last", busy, 0);

      // R4 cancel in window
      cyc(0, 0, 0, 1, 3, 1, "R4");
      cyc(0, 0, 0, 1, 6, 1, "R4");
      cyc(1, 0, 0, 0, 0, 1, "R4");
      check_eq("R4", "abort pair", {abort_read, abort_dirty}, 32'h2);
      check_eq("R4", "mask", erase_mask, 0);
      cyc(0, 0, 0, 0, 0, 1, "R4");
      check_eq("R4", "pulse width", abort_read, 0);

      // R5 abort while erasing
      cyc(0, 0, 0, 1, 2, 1, "R5");
      ticks(WT + 1, "R5");
      cyc(0, 0, 0, 1, 4, 1, "R5");
      check_eq("R5", "abort pair", {abort_read, abort_dirty}, 32'h3);
      check_eq("R5", "busy", busy, 0);

      // R11 precedence: other wins over sector erase in read mode -> stays read
      cyc(1, 0, 0, 1, 1, 1, "R11");
      check_eq("R11", "busy", busy, 0);

      // R6 suspend inside window, R7 resume without window
      cyc(0, 0, 0, 1, 7, 1, "R6");
      cyc(0, 0, 0, 1, 0, 1, "R6");
      cyc(0, 1, 0, 0, 0, 1, "R6");
      cyc(1, 0, 0, 0, 0, 1, "R6");
      check_eq("R6", "ignored while pending", busy, 1);
      ticks(ST, "R6");
      check_eq("R6", "suspended", suspended, 1);
      check_eq("R6", "mask kept", erase_mask, 32'h81);
      cyc(0, 0, 0, 1, 3, 1, "R7");
      cyc(1, 0, 0, 0, 0, 1, "R7");
      check_eq("R7", "still suspended", suspended, 1);
      cyc(0, 0, 1, 0, 0, 0, "R7");
      check_eq("R7", "window", window_open, 0);
      check_eq("R7", "busy", busy, 1);
      ticks(ET - 1, "R7");
      cyc(0, 1, 0, 0, 0, 1, "R7");
      ticks(ST, "R7");
      cyc(0, 0, 1, 0, 0, 0, "R7");
      ticks(ET - 1, "R7");
      check_eq("R7", "count restarted", erase_mask, 32'h81);
      finish_run("R7");

      // R8 all protected
      protect_mask = 8'h0C;
      cyc(0, 0, 0, 1, 2, 1, "R8");
      cyc(0, 0, 0, 1, 3, 1, "R8");
      ticks(WT, "R8");
      check_eq("R8", "busy", busy, 1);
      check_eq("R8", "mask", erase_mask, 0);
      ticks(NT, "R8");
      check_eq("R8", "busy done", busy, 0);
      check_eq("R8", "no abort", abort_read, 0);
      // R8 partial protection
      protect_mask = 8'h10;
      cyc(0, 0, 0, 1, 4, 1, "R8");
      cyc(0, 0, 0, 1, 6, 1, "R8");
      ticks(WT, "R8");
      check_eq("R8", "partial mask", erase_mask, 32'h40);
      finish_run("R8");

      // random phase against the bench model (R2-R11)
      for (int i = 0; i < 4000; i++) begin
         int p;
         p = $urandom_range(99);
         if ($urandom_range(49) == 0) protect_mask = NS'($urandom);
         cyc(p < 4, (p >= 4 && p < 10), (p >= 10 && p < 17), (p >= 17 && p < 32) || (p == 99),
             $urandom_range(NS - 1), $urandom_range(1), "R3 R5 R6 R9 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule